// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind a byte-wide register port with a 2-bit address. Addresses 0 to 2 reach the counters' data ports. Address 3 takes a control word that sets up a counter or takes a snapshot of it. A counter's start value goes in one byte at a time, in the byte order chosen by the control word. The counter then runs on a count-enable strobe `cnt_tick`, which stands for one period of the slow counting clock. Each counter drives one output. That output can be a one-time terminal-count flag, a periodic one-tick low pulse, or a square wave. A start value of N divides the tick rate by N.

Software can read a counter while it runs. It can read the live value directly, or it can first issue a latch command. The latch command freezes a snapshot, which stays held until every byte of it has been read. Counting can be in binary or in four-digit BCD. A start value of zero stands for the full range of the chosen number system.

Top module: `pit_timer`

## Requirements
- R1: After reset, all three outputs are low. Each counter reads 0 in 16-bit access, low byte first, and waits for a start value.
- R2: A control word is written to address 3. Bits 7:6 select the counter and bits 5:4 select the access mode: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits 3:1 select the counting mode and bit 0 selects BCD. A control word whose access mode is not latch takes effect as follows: the counter stops and waits, its byte phase returns to low, and on the next cycle its output takes the level given by mode bit 2 (low for code 000, high for codes 010 and 011).
- R3: The start value is loaded on the write that completes it. In low-byte mode the upper byte is 0. In high-byte mode the lower byte is 0. In 16-bit mode two writes are needed, low byte first. A tick in the same cycle as a data write to that counter is not counted.
- R4: In counting mode code 000, the output stays low for N ticks after the load and then rises. It stays high until the counter is set up or loaded again.
- R5: In counting mode codes 010 and 110, the output falls N-1 ticks after the load and rises one tick later, when the counter reloads. The pattern repeats every N ticks.
- R6: In counting mode codes 011 and 111, the output is a square wave with a period of N ticks. It starts high, stays high for ceil(N/2) ticks and stays low for floor(N/2) ticks.
- R7: A start value of 0 counts as 65536 in binary and as 10000 in BCD.
- R8: In BCD the count is held and read as four BCD digits, and it decrements from 0000 to 9999.
- R9: A latch command (access bits 00) copies the live count. Reads then return that copy while counting goes on.
- R10: The copy is released once all of its bytes have been read under the counter's access mode. A latch command issued while a copy is still held is ignored.
- R11: In 16-bit access, successive reads alternate between the low byte and the high byte, starting with the low byte. In single-byte access, every read returns the selected byte.
- R12: A counter does not count while it waits for a start value, or in any cycle without `cnt_tick`. An output changes only in a cycle with a tick or a write.
- R13: A read of address 3 returns 0. A control word with select bits 11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle count enable, one per counting-clock period |
| addr | input | 2 | Register address: 0 to 2 counters, 3 control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; the side effects of a read take place at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port, combinational |
| tmr_out | output | 3 | Counter outputs, bit k for counter k |

## Verification
The assertions assume that a read and a write never occur in the same cycle. They also assume that rate-generator and square-wave start values are never 1. The stimulus keeps to these rules: it drives one strobe per bus cycle and draws random start values between 2 and 300. The interval checks measure, tick by tick, when each output edge occurs, and compare it with intervals that the bench computes from N. Directed cases cover zero start values in both number systems, odd square-wave divisors, and the hold and release of a latched value.

// File: rtl/pit_timer.sv
`timescale 1ns/1ps
module pit_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_tick,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [2:0] tmr_out
);
  localparam int NCH = 3;
  localparam logic [1:0] CTRL = 2'd3;
  localparam logic [1:0] ACC_LATCH = 2'd0, ACC_LO = 2'd1, ACC_HI = 2'd2, ACC_WORD = 2'd3;

  function automatic logic [15:0] dec1(input logic [15:0] v, input logic bcd);
    logic [15:0] r;
    logic b;
    r = v - 16'd1;
    if (bcd) begin
      r = v;
      b = 1'b1;
      for (int d = 0; d < 4; d++)
        if (b) begin
          if (v[4*d +: 4] == 4'd0) r[4*d +: 4] = 4'd9;
          else begin
            r[4*d +: 4] = v[4*d +: 4] - 4'd1;
            b = 1'b0;
          end
        end
    end
    return r;
  endfunction

  logic cw_wr;
  logic [7:0] rd_byte [4];
  assign cw_wr = wr_en && addr == CTRL;
  assign rd_byte[3] = 8'h00;
  assign rdata = rd_byte[addr];

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      logic [1:0]  acc, mode;
      logic        bcd, held, wait_ld, wr_hi, rd_hi, q;
      logic [15:0] reload, count, hold, new_val, src, dn1, dn2, even_rl;
      logic        sel_cw, do_latch, do_setup, hit_wr, hit_rd, load_done;
      logic        is_rate, is_sq, sq_term;

      assign sel_cw    = cw_wr && wdata[7:6] == 2'(i);
      assign do_latch  = sel_cw && wdata[5:4] == ACC_LATCH;
      assign do_setup  = sel_cw && wdata[5:4] != ACC_LATCH;
      assign hit_wr    = wr_en && addr == 2'(i);
      assign hit_rd    = rd_en && addr == 2'(i);
      assign load_done = hit_wr && (acc != ACC_WORD || wr_hi);
      assign is_rate   = mode == 2'b10;
      assign is_sq     = mode == 2'b11;
      assign dn1       = dec1(count, bcd);
      assign dn2       = dec1(dn1, bcd);
      assign even_rl   = {reload[15:1], 1'b0};
      assign sq_term   = (q && reload[0]) ? count == 16'd0 : count == 16'd2;
      assign src       = held ? hold : count;
      assign tmr_out[i] = q;

      always_comb
        case (acc)
          ACC_LO:  new_val = {8'h00, wdata};
          ACC_HI:  new_val = {wdata, 8'h00};
          default: new_val = {wdata, reload[7:0]};
        endcase

      assign rd_byte[i] = (acc == ACC_HI || (acc == ACC_WORD && rd_hi)) ? src[15:8] : src[7:0];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          acc <= ACC_WORD; mode <= 2'b00; bcd <= 1'b0;
          reload <= '0; count <= '0; hold <= '0;
          held <= 1'b0; wait_ld <= 1'b1; wr_hi <= 1'b0; rd_hi <= 1'b0; q <= 1'b0;
        end else begin
          if (do_setup) begin
            acc <= wdata[5:4]; mode <= wdata[2:1]; bcd <= wdata[0];
            wait_ld <= 1'b1; wr_hi <= 1'b0; rd_hi <= 1'b0; held <= 1'b0; q <= wdata[2];
          end else if (hit_wr) begin
            if (acc == ACC_WORD) wr_hi <= ~wr_hi;
            if (load_done) begin
              reload  <= new_val;
              count   <= is_sq ? {new_val[15:1], 1'b0} : new_val;
              wait_ld <= 1'b0;
              q       <= is_rate || is_sq;
            end else reload[7:0] <= wdata;
          end else if (cnt_tick && !wait_ld) begin
            if (is_sq) begin
              if (sq_term) begin q <= ~q; count <= even_rl; end
              else count <= dn2;
            end else if (is_rate) begin
              if (count == 16'd1) begin q <= 1'b1; count <= reload; end
              else begin
                count <= dn1;
                if (count == 16'd2) q <= 1'b0;
              end
            end else begin
              count <= dn1;
              if (count == 16'd1) q <= 1'b1;
            end
          end
          if (do_latch && !held) begin
            held <= 1'b1; hold <= count; rd_hi <= 1'b0;
          end
          if (hit_rd) begin
            if (acc == ACC_WORD) rd_hi <= ~rd_hi;
            if (held && (acc != ACC_WORD || rd_hi)) held <= 1'b0;
          end
        end
    end
  endgenerate
endmodule

// File: rtl/pit_timer_chk.sv
`timescale 1ns/1ps
module pit_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_tick,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [2:0] tmr_out
);
  assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> tmr_out == 3'b000);

  genvar k;
  generate
    for (k = 0; k < 3; k++) begin : g_lvl
      assert_setup_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd3 && wdata[7:6] == 2'(k) && wdata[5:4] != 2'b00)
          |=> tmr_out[k] == $past(wdata[2]));
    end
  endgenerate

  assert_quiet_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !wr_en) |=> $stable(tmr_out));

  assert_ctrl_read_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |-> rdata == 8'h00);
endmodule

bind pit_timer pit_timer_chk u_chk (.*);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
  logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] tmr_out;
  int nchk = 0, nerr = 0;

  pit_timer u0 (.clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .addr(addr), .wr_en(wr_en),
                .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out));

  always #2 clk = ~clk;

  function automatic int eff(int n, bit bcd);
    return (n == 0) ? (bcd ? 10000 : 65536) : n;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cw(input logic [1:0] sel, input logic [1:0] acc, input logic [2:0] md, input logic bcd);
    wr(2'd3, {sel, acc, md, bcd});
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic measure(int k, int lim, output int t);
    logic v;
    v = tmr_out[k];
    t = 0;
    cnt_tick = 1'b1;
    while (t < lim) begin
      @(negedge clk);
      t++;
      if (tmr_out[k] != v) break;
    end
    cnt_tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int t, v, v2, n, k, code, kind;
    logic [7:0] b;
    logic [2:0] o;
    int codes [5] = '{0, 2, 3, 6, 7};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 outputs after reset", int'(tmr_out), 0);
    rd16(2'd0, v);
    chk("R1 counter0 value after reset", v, 0);

    // R3 low byte only, R11 repeated single-byte reads, R5 pulse timing
    cw(2'd0, 2'b01, 3'b010, 1'b0);
    chk("R2 rate mode level after setup", int'(tmr_out[0]), 1);
    wr(2'd0, 8'd5);
    rd(2'd0, b); chk("R3 low-byte load read 1", b, 5);
    rd(2'd0, b); chk("R11 low-byte load read 2", b, 5);
    measure(0, 100, t); chk("R5 fall after N-1", t, 4);
    measure(0, 100, t); chk("R5 one-tick low", t, 1);
    measure(0, 100, t); chk("R5 next fall", t, 4);

    // R3 high byte only, R4 terminal count
    cw(2'd0, 2'b10, 3'b000, 1'b0);
    chk("R2 mode0 level after setup", int'(tmr_out[0]), 0);
    wr(2'd0, 8'd1);
    rd(2'd0, b); chk("R3 high-byte load", b, 1);
    measure(0, 1000, t); chk("R4 rise after N", t, 256);
    ticks(300);
    chk("R4 output stays high", int'(tmr_out[0]), 1);

    // R9 R10 latch behaviour
    cw(2'd1, 2'b11, 3'b010, 1'b0);
    wr(2'd1, 8'hE8); wr(2'd1, 8'h03);
    ticks(10);
    cw(2'd1, 2'b00, 3'b000, 1'b0);
    ticks(5);
    rd16(2'd1, v); chk("R9 latched value", v, 990);
    rd16(2'd1, v); chk("R10 live after release", v, 985);
    cw(2'd1, 2'b00, 3'b000, 1'b0);
    ticks(3);
    cw(2'd1, 2'b00, 3'b000, 1'b0);
    ticks(2);
    rd16(2'd1, v); chk("R10 second latch ignored", v, 985);
    rd16(2'd1, v); chk("R10 live after second release", v, 980);

    // R11 byte phase reset by control word
    rd(2'd1, b);
    cw(2'd1, 2'b11, 3'b011, 1'b0);
    rd(2'd1, b); chk("R11 phase reset to low byte", b, 8'hD4);
    rd(2'd1, b); chk("R11 then high byte", b, 8'h03);

    // R12 no counting while waiting / without ticks
    wr(2'd1, 8'h10);
    ticks(20);
    rd16(2'd1, v); chk("R12 no count while waiting", v, 980);
    chk("R12 output holds while waiting", int'(tmr_out[1]), 1);
    wr(2'd1, 8'h00);
    repeat (10) @(negedge clk);
    chk("R12 output without ticks", int'(tmr_out[1]), 1);
    measure(1, 100, t); chk("R6 even high half", t, 8);
    measure(1, 100, t); chk("R6 even low half", t, 8);

    // R6 odd divisor
    cw(2'd1, 2'b01, 3'b011, 1'b0);
    wr(2'd1, 8'd7);
    measure(1, 100, t); chk("R6 odd high half", t, 4);
    measure(1, 100, t); chk("R6 odd low half", t, 3);

    // R8 R7 BCD countdown and wrap
    cw(2'd2, 2'b11, 3'b000, 1'b1);
    wr(2'd2, 8'h00); wr(2'd2, 8'h01);
    ticks(1);
    rd16(2'd2, v); chk("R8 BCD decrement 0100", v, 16'h0099);
    ticks(99);
    chk("R4 BCD terminal output", int'(tmr_out[2]), 1);
    ticks(1);
    rd16(2'd2, v); chk("R8 BCD wrap to 9999", v, 16'h9999);

    // R13 read of control port and select 11 ignored
    rd(2'd3, b); chk("R13 control read zero", b, 0);
    o = tmr_out;
    rd16(2'd2, v);
    wr(2'd3, 8'hF6);
    chk("R13 select 11 outputs unchanged", int'(tmr_out), int'(o));
    rd16(2'd2, v2);
    chk("R13 select 11 count unchanged", v2, v);

    // R7 zero start values
    cw(2'd0, 2'b11, 3'b000, 1'b0);
    wr(2'd0, 8'h00); wr(2'd0, 8'h00);
    measure(0, 70000, t); chk("R7 binary zero mode0", t, eff(0, 1'b0));
    cw(2'd2, 2'b11, 3'b010, 1'b1);
    wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    measure(2, 20000, t); chk("R7 BCD zero rate fall", t, eff(0, 1'b1) - 1);
    measure(2, 20000, t); chk("R7 BCD zero rate pulse", t, 1);
    cw(2'd1, 2'b11, 3'b111, 1'b1);
    wr(2'd1, 8'h00); wr(2'd1, 8'h00);
    measure(1, 20000, t); chk("R7 BCD zero square high", t, eff(0, 1'b1) / 2);

    // constrained random runs
    for (int it = 0; it < 12; it++) begin
      k = $urandom_range(0, 2);
      code = codes[$urandom_range(0, 4)];
      kind = code & 3;
      n = $urandom_range(2, 300);
      cw(2'(k), 2'b11, 3'(code), 1'b0);
      wr(2'(k), 8'(n)); wr(2'(k), 8'(n >> 8));
      if (kind == 0) begin
        chk("R4 random level at load", int'(tmr_out[k]), 0);
        measure(k, 1000, t); chk("R4 random rise", t, n);
      end else if (kind == 2) begin
        measure(k, 1000, t); chk("R5 random fall", t, n - 1);
        measure(k, 1000, t); chk("R5 random pulse", t, 1);
      end else begin
        measure(k, 1000, t); chk("R6 random high", t, (n + 1) / 2);
        measure(k, 1000, t); chk("R6 random low", t, n / 2);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule